// File: doc/BRIEF.md
# Granted-Step Clock Source

This block produces a clock level for an emulator that advances simulated time in steps of varying size. The block holds a pending request: the number of time units it wants to elapse before its clock next changes level. In every cycle of the emulator clock, an outside granter offers a step size. If the step matches the pending request exactly, the clock level flips in that same cycle and the request is reloaded with the duration of the phase just begun. Any other step is taken off the pending request.

The high and low phase durations are unsigned inputs. They are sampled only at the moment of a flip, so a change to them takes effect from the next phase. The pending request is an output so that the granter can pick the next step. A granter that always offers exactly the request makes the clock change level every cycle. A granter that caps its step makes the request count down over several cycles.

Top module: `stepclk_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the request register loads `INIT_REQ` (default 0) and the stored level loads 0. After reset, `req_out` equals `INIT_REQ`, and `clk_out` is 0 for any step that differs from `INIT_REQ`.
- R2: A grant happens in a cycle exactly when `step_in` equals `req_out`. All 32 bits are compared.
- R3: `clk_out` is combinational. It equals the stored level when there is no grant, and the inverse of the stored level in a grant cycle.
- R4: The stored level takes the value of `clk_out` at every rising edge of `clk` when out of reset. As a result, the value `clk_out` shows in a grant cycle persists in later cycles until the next grant.
- R5: In a grant cycle where the stored level is 1, the next `req_out` is `dur_low`. In a grant cycle where the stored level is 0, the next `req_out` is `dur_high`.
- R6: Outside a grant, the next `req_out` is `req_out - step_in`, truncated to 32 bits. When the step is larger than the request, the result wraps modulo 2^32.
- R7: With a granter whose steps never exceed the request, the steps granted from the cycle after a flip up to and including the next flip add up to `dur_high` for a high phase and `dur_low` for a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_in | input | 32 | Time step granted in this cycle |
| dur_high | input | 32 | Length of a high phase in time units |
| dur_low | input | 32 | Length of a low phase in time units |
| req_out | output | 32 | Pending time request |
| clk_out | output | 1 | Emulated clock level |

## Verification
`clk_out` answers `step_in` in the same cycle, with no register in the path. `req_out` and the stored level change at the next rising edge, one register later. The bench drives each step at a falling edge and records the request and level it expects for that cycle in a queue. A monitor then compares the ports 2 ns later, still ahead of the rising edge that consumes the step. The phase-length checks add up the granted steps between two observed flips, so they rely only on the level seen at the ports.

// File: rtl/stepclk_pkg.sv
// Package: shared types for the granted-step clock source.
// Assumes: time quantities are unsigned and all share one width.
package stepclk_pkg;
    // Level of the emulated clock, which also names the phase in progress.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;
endpackage

// File: rtl/stepclk_match.sv
// Module: stepclk_match
// Does: flags a grant when the offered step equals the pending request.
// Assumes: both operands are the same width and are compared in full.
module stepclk_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] step_i,
    output logic         hit_o
);
    // Equality over the full width: no partial grants.
    always_comb begin
        hit_o = (req_i == step_i);
    end
endmodule

// File: rtl/stepclk_level.sv
// Module: stepclk_level
// Does: holds the last clock level and flips it combinationally on a grant.
// Assumes: synchronous active-low reset, and the reset level is low.
module stepclk_level
    import stepclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit_i,
    output level_e prev_o,
    output logic   lvl_o
);
    level_e prev_q;

    // Output level: the stored level, inverted in a grant cycle.
    always_comb begin
        lvl_o = hit_i ? ~prev_q : prev_q;
    end

    // Capture the output level at every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LVL_LOW;
        else        prev_q <= level_e'(lvl_o);
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/stepclk_req.sv
// Module: stepclk_req
// Does: keeps the pending request, reloading a phase duration on a grant and
//       counting down by the granted step otherwise.
// Assumes: wrap on underflow is acceptable; durations are sampled at a grant.
module stepclk_req
    import stepclk_pkg::*;
#(
    parameter int           W        = 32,
    parameter logic [W-1:0] INIT_REQ = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  level_e       prev_i,
    input  logic [W-1:0] step_i,
    input  logic [W-1:0] dur_high_i,
    input  logic [W-1:0] dur_low_i,
    output logic [W-1:0] req_o
);
    logic [W-1:0] req_q;
    logic [W-1:0] reload;
    logic [W-1:0] remain;
    logic [W-1:0] req_d;

    // Duration of the phase that begins at a flip.
    always_comb begin
        reload = (prev_i == LVL_HIGH) ? dur_low_i : dur_high_i;
    end

    // Remaining request after a step that is not a grant; truncated to W bits.
    always_comb begin
        remain = req_q - step_i;
    end

    // Next request: reload on a grant, otherwise count down.
    always_comb begin
        req_d = hit_i ? reload : remain;
    end

    // Request register with reset to the initial delay.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= INIT_REQ;
        else        req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/stepclk_gen.sv
// Module: stepclk_gen (top)
// Does: emulated clock whose level flips only when the emulator grants
//       exactly the pending request.
// Assumes: one granted step per clk cycle, and the granter reads req_out.
module stepclk_gen
    import stepclk_pkg::*;
#(
    parameter int           W        = 32,
    parameter logic [W-1:0] INIT_REQ = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] step_in,
    input  logic [W-1:0] dur_high,
    input  logic [W-1:0] dur_low,
    output logic [W-1:0] req_out,
    output logic         clk_out
);
    logic   hit;
    level_e prev_lvl;
    logic [W-1:0] req_cur;

    stepclk_match #(.W(W)) u_match (
        .req_i  (req_cur),
        .step_i (step_in),
        .hit_o  (hit)
    );

    stepclk_level u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .prev_o (prev_lvl),
        .lvl_o  (clk_out)
    );

    stepclk_req #(.W(W), .INIT_REQ(INIT_REQ)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .prev_i     (prev_lvl),
        .step_i     (step_in),
        .dur_high_i (dur_high),
        .dur_low_i  (dur_low),
        .req_o      (req_cur)
    );

    assign req_out = req_cur;
endmodule

// File: rtl/stepclk_gen_chk.sv
// Module: stepclk_gen_chk
// Does: temporal checks on the ports and the stored level of stepclk_gen.
// Assumes: bound to every stepclk_gen instance.
module stepclk_gen_chk #(
    parameter int           W        = 32,
    parameter logic [W-1:0] INIT_REQ = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] step_in,
    input logic [W-1:0] dur_high,
    input logic [W-1:0] dur_low,
    input logic [W-1:0] req_out,
    input logic         clk_out,
    input logic         prev_lvl
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (req_out == INIT_REQ && prev_lvl == 1'b0));

    assert_flip_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out == step_in) |-> (clk_out != prev_lvl));

    assert_hold_without_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != step_in) |-> (clk_out == prev_lvl));

    assert_level_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (prev_lvl == $past(clk_out)));

    assert_reload_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out == step_in && prev_lvl) |=> (req_out == $past(dur_low)));

    assert_reload_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out == step_in && !prev_lvl) |=> (req_out == $past(dur_high)));

    assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != step_in) |=> (req_out == W'($past(req_out) - $past(step_in))));
endmodule

bind stepclk_gen stepclk_gen_chk #(.W(W), .INIT_REQ(INIT_REQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_in  (step_in),
    .dur_high (dur_high),
    .dur_low  (dur_low),
    .req_out  (req_out),
    .clk_out  (clk_out),
    .prev_lvl (prev_lvl)
);

// File: tb/stepclk_gen_tb.sv
module stepclk_gen_tb;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] req;
        logic         lvl;
        logic [W-1:0] step;
        logic [W-1:0] dh;
        logic [W-1:0] dl;
        bit           fresh;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] step_in = '0;
    logic [W-1:0] dur_high = '0;
    logic [W-1:0] dur_low = '0;
    logic [W-1:0] req_out;
    logic         clk_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t q[$];

    // reference state, advanced once per driven cycle
    logic [W-1:0] m_req = '0;
    logic         m_prev = 1'b0;
    bit           m_fresh = 1'b0;

    stepclk_gen #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in),
        .dur_high(dur_high), .dur_low(dur_low),
        .req_out(req_out), .clk_out(clk_out)
    );

    always #5 clk = ~clk;

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step_in = '0;
        repeat (2) @(negedge clk);
        m_req = '0;
        m_prev = 1'b0;
        m_fresh = 1'b1;
    endtask

    // Drive one cycle; a capped granter offers min(req_out, cap).
    task automatic drive(input logic [W-1:0] step, input bit capped,
                         input logic [W-1:0] cap, input logic [W-1:0] dh,
                         input logic [W-1:0] dl, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        rst_n = 1'b1;
        if (capped) step = (req_out < cap) ? req_out : cap;
        step_in = step;
        dur_high = dh;
        dur_low = dl;
        hit = (m_req == step);
        e.req = m_req;
        e.lvl = hit ? ~m_prev : m_prev;
        e.step = step;
        e.dh = dh;
        e.dl = dl;
        e.fresh = m_fresh;
        e.tag = tag;
        q.push_back(e);
        m_fresh = 1'b0;
        m_req = hit ? (m_prev ? dl : dh) : m_req - step;
        m_prev = e.lvl;
    endtask

    // Monitor: compare ports against queued expectations, and add up phase lengths.
    initial begin
        logic         last_lvl;
        logic [W-1:0] acc;
        bit           armed;
        last_lvl = 1'b0;
        acc = '0;
        armed = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.fresh) begin
                    last_lvl = 1'b0;
                    acc = '0;
                    armed = 1'b0;
                end
                checks++;
                if (req_out !== e.req) begin
                    errors++;
                    $display("FAIL %s req_out actual=%0h expected=%0h", e.tag, req_out, e.req);
                end
                checks++;
                if (clk_out !== e.lvl) begin
                    errors++;
                    $display("FAIL %s clk_out actual=%0b expected=%0b", e.tag, clk_out, e.lvl);
                end
                acc = acc + e.step;
                if (clk_out !== last_lvl) begin
                    if (armed) begin
                        checks++;
                        if (acc !== (last_lvl ? e.dh : e.dl)) begin
                            errors++;
                            $display("FAIL R7 phase length actual=%0d expected=%0d",
                                     acc, last_lvl ? e.dh : e.dl);
                        end
                    end
                    armed = 1'b1;
                    acc = '0;
                end
                last_lvl = clk_out;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, no grant because the step differs from the request
        do_reset();
        drive(32'd5, 1'b0, '0, 32'd10, 32'd6, "R1");
        drive(32'd1, 1'b0, '0, 32'd10, 32'd6, "R6 wrap after reset");

        // R2 R3 R5: zero step grants the zero request and the level rises
        do_reset();
        drive(32'd0, 1'b0, '0, 32'd10, 32'd6, "R2 R3 first flip");
        // R6 countdown, R4 level holds
        drive(32'd3, 1'b0, '0, 32'd10, 32'd6, "R5 R6 R4");
        drive(32'd3, 1'b0, '0, 32'd10, 32'd6, "R6 R4");
        drive(32'd3, 1'b0, '0, 32'd10, 32'd6, "R6");
        // R2 R3: exact grant flips to low; R7 checks the high phase of 10
        drive(32'd1, 1'b0, '0, 32'd10, 32'd6, "R2 R3 falling flip");
        // R5: the low duration was loaded
        drive(32'd2, 1'b0, '0, 32'd10, 32'd6, "R5 low reload");
        // R6: a step larger than the request wraps
        drive(32'd10, 1'b0, '0, 32'd10, 32'd6, "R6 underflow");
        drive(32'd0, 1'b0, '0, 32'd10, 32'd6, "R6 wrapped value");

        // R7: a granter that always grants the full request
        do_reset();
        for (int i = 0; i < 12; i++)
            drive('0, 1'b1, 32'hFFFF_FFFF, 32'd40, 32'd25, "R7 full grant");

        // R7: a capped granter, so phases take several steps
        do_reset();
        for (int i = 0; i < 60; i++)
            drive('0, 1'b1, 32'd5, 32'd13, 32'd7, "R7 capped grant");

        // R2: requests that differ only in the top bit do not grant
        do_reset();
        drive(32'd0, 1'b0, '0, 32'h8000_0004, 32'd3, "R2 load wide");
        drive(32'd4, 1'b0, '0, 32'h8000_0004, 32'd3, "R2 partial step");
        drive(32'd0, 1'b0, '0, 32'h8000_0004, 32'd3, "R2 top bit no grant");
        drive(32'h8000_0000, 1'b0, '0, 32'h8000_0004, 32'd3, "R2 wide grant");
        drive(32'd0, 1'b0, '0, 32'h8000_0004, 32'd3, "R5 after wide grant");

        @(negedge clk);
        #4;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule